// File: doc/BRIEF.md
# Two-Level Device Page Table Walker

This block turns a 32-bit device virtual address into a 40-bit physical address by walking a two-level page table held in memory. A request carries the virtual address and a write flag. The walker reads the first-level entry through a single-outstanding memory read port. It checks that entry, then reads and checks the second-level entry. It answers with either the translated address or a fault reason.

Pages are 4 KiB. The top ten address bits select a first-level entry, the next ten select a second-level entry, and the low twelve bits pass through as the page offset. Each entry word carries three flags:
- bit 0 marks it as valid;
- bit 1 forces a fault;
- bit 2 permits writes.

Faulting accesses are not dropped. They are answered with an address inside a programmable safe page. The first fault is also held, with its virtual address, in a small log until software clears it. A global enable allows untranslated pass-through.

Top module: `ptw_walker`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, `mem_rd_req` is 0 and `fault_reason` is 00.
- R2: The first-level read address is {`cfg_root_base`[31:12], va[31:22], 2'b00}. The second-level read address is {first-level entry[31:12], va[21:12], 2'b00}.
- R3: When both entries are valid and the access is allowed, `rsp_paddr` = {L2 entry[11:4], L2 entry[31:12], va[11:0]} and `rsp_reason` = 00.
- R4: A first-level entry with bit 0 clear or bit 1 set gives reason 01, and no second-level read is issued.
- R5: A second-level entry with bit 0 clear or bit 1 set gives reason 10.
- R6: A write whose second-level entry has bit 2 clear gives reason 11. A read of the same entry translates normally.
- R7: Every faulting response is still delivered, with `rsp_paddr` = {`cfg_safe_page`[39:12], va[11:0]}.
- R8: Only one walk runs at a time. `req_ready` is low from acceptance until after the response, and `rsp_valid` is a single-cycle pulse.
- R9: While `cfg_enable` is 0, an accepted request is answered in the next cycle with `rsp_paddr` = {8'h00, va} and reason 00, and no memory read is issued.
- R10: The fault log captures the reason and virtual address of the first fault while it is empty. Later faults do not overwrite it. A `fault_clear` pulse returns the reason to 00.
- R11: The walker waits any number of cycles for `mem_rd_data_valid` at each level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | 1 = translate, 0 = pass through |
| cfg_root_base | input | 32 | First-level table base (4 KiB aligned, bits 11:0 ignored) |
| cfg_safe_page | input | 40 | Safe page address for faulting accesses |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 40 | Translated or safe-page address |
| rsp_reason | output | 2 | 00 ok, 01 L1 invalid, 10 L2 invalid, 11 write denied |
| mem_rd_req | output | 1 | One-cycle table read request |
| mem_rd_addr | output | 32 | Byte address of the entry word |
| mem_rd_data_valid | input | 1 | Read data strobe |
| mem_rd_data | input | 32 | Entry word |
| fault_clear | input | 1 | Empties the fault log |
| fault_reason | output | 2 | Logged fault reason |
| fault_vaddr | output | 32 | Logged faulting virtual address |

## Verification
The bench uses the default 10/10/12 split with a small memory of four pages: one first-level table and three second-level tables. Three of those tables sit behind first-level pointers with different high address bits. Every one of their 1024 entries is walked as both a read and a write. Every first-level slot that is invalid or exception-marked is also walked. This brings every entry-flag combination, the permission rule and the safe-page redirect within reach, under read latencies that vary from one to three cycles. A pass-through sweep, and a fault-log sequence of first fault, later fault and clear, cover the remaining modes.

// File: rtl/ptw_pkg.sv
// Package: shared widths, field positions and encodings for the page table walker.
// Assumes a fixed two-level layout with 4 KiB pages and 32-bit entries.
package ptw_pkg;
    parameter int VA_W      = 32;
    parameter int PA_W      = 40;
    parameter int ENTRY_W   = 32;
    parameter int OFS_W     = 12;
    parameter int IDX_W     = 10;
    parameter int HI_W      = PA_W - VA_W;       // extra physical bits kept in the entry
    parameter int PFN_W     = VA_W - OFS_W;      // page frame number width
    parameter int WORD_SH   = 2;                 // byte shift for a 32-bit word
    parameter int BIT_VALID = 0;
    parameter int BIT_EXC   = 1;
    parameter int BIT_WR    = 2;
    parameter int HI_LSB    = 4;

    typedef enum logic [1:0] {
        RSN_NONE = 2'b00,
        RSN_L1   = 2'b01,
        RSN_L2   = 2'b10,
        RSN_PERM = 2'b11
    } reason_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_L1_REQ,
        S_L1_WAIT,
        S_L2_REQ,
        S_L2_WAIT,
        S_RESP
    } walk_state_e;
endpackage

// File: rtl/ptw_entry_chk.sv
// Module: decodes one table entry word into its usable fields.
// Assumes bit 0 = valid, bit 1 = exception, bit 2 = writeable, and that the
// upper bits hold a page frame number. It is purely combinational.
module ptw_entry_chk
    import ptw_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    output logic               usable,
    output logic               writeable,
    output logic [PFN_W-1:0]   pfn,
    output logic [HI_W-1:0]    hi_bits
);
    // Field extraction and the usability rule shared by both levels.
    always_comb begin
        usable    = entry[BIT_VALID] & ~entry[BIT_EXC];
        writeable = entry[BIT_WR];
        pfn       = entry[ENTRY_W-1:OFS_W];
        hi_bits   = entry[HI_LSB +: HI_W];
    end
endmodule

// File: rtl/ptw_fault_log.sv
// Module: holds the first fault's reason and virtual address until cleared.
// Assumes rec is a one-cycle strobe. A fault arriving in the same cycle as a
// clear is recorded.
module ptw_fault_log
    import ptw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rec,
    input  logic [1:0]      rec_reason,
    input  logic [VA_W-1:0] rec_vaddr,
    input  logic            clear,
    output logic [1:0]      log_reason,
    output logic [VA_W-1:0] log_vaddr
);
    logic empty;
    assign empty = (log_reason == RSN_NONE);

    // Capture when empty (or being cleared), otherwise hold or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            log_reason <= RSN_NONE;
            log_vaddr  <= '0;
        end else if (rec && (empty || clear)) begin
            log_reason <= rec_reason;
            log_vaddr  <= rec_vaddr;
        end else if (clear) begin
            log_reason <= RSN_NONE;
            log_vaddr  <= '0;
        end
    end

    // R10: a held fault stays put unless cleared.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (log_reason != RSN_NONE && !clear) |=> ($stable(log_reason) && $stable(log_vaddr)));
endmodule

// File: rtl/ptw_walker.sv
// Module: two-level page table walker, one walk at a time.
// Assumes memory returns exactly one data strobe per read request, after one or
// more cycles, and that the configuration inputs are stable during a walk.
module ptw_walker
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic [VA_W-1:0]    cfg_root_base,
    input  logic [PA_W-1:0]    cfg_safe_page,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_write,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [1:0]         rsp_reason,
    output logic               mem_rd_req,
    output logic [VA_W-1:0]    mem_rd_addr,
    input  logic               mem_rd_data_valid,
    input  logic [ENTRY_W-1:0] mem_rd_data,
    input  logic               fault_clear,
    output logic [1:0]         fault_reason,
    output logic [VA_W-1:0]    fault_vaddr
);
    localparam int L1_LSB = OFS_W + IDX_W;

    walk_state_e        st;
    logic [VA_W-1:0]    va_q;
    logic               wr_q;
    logic [PFN_W-1:0]   l2_base_q;
    logic [PA_W-1:0]    pa_q;
    reason_e            rsn_q;

    logic               ent_usable;
    logic               ent_wr;
    logic [PFN_W-1:0]   ent_pfn;
    logic [HI_W-1:0]    ent_hi;
    logic [PA_W-1:0]    safe_pa;

    ptw_entry_chk u_chk (
        .entry     (mem_rd_data),
        .usable    (ent_usable),
        .writeable (ent_wr),
        .pfn       (ent_pfn),
        .hi_bits   (ent_hi)
    );

    // Safe-page redirect keeps the page offset of the faulting access.
    assign safe_pa = {cfg_safe_page[PA_W-1:OFS_W], va_q[OFS_W-1:0]};

    // Walk sequencing: accept, read L1, read L2, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            va_q      <= '0;
            wr_q      <= 1'b0;
            l2_base_q <= '0;
            pa_q      <= '0;
            rsn_q     <= RSN_NONE;
        end else begin
            case (st)
                S_IDLE: if (req_valid) begin
                    va_q <= req_vaddr;
                    wr_q <= req_write;
                    if (cfg_enable) begin
                        st <= S_L1_REQ;
                    end else begin
                        pa_q  <= {{HI_W{1'b0}}, req_vaddr};
                        rsn_q <= RSN_NONE;
                        st    <= S_RESP;
                    end
                end
                S_L1_REQ: st <= S_L1_WAIT;
                S_L1_WAIT: if (mem_rd_data_valid) begin
                    if (ent_usable) begin
                        l2_base_q <= ent_pfn;
                        st        <= S_L2_REQ;
                    end else begin
                        pa_q  <= safe_pa;
                        rsn_q <= RSN_L1;
                        st    <= S_RESP;
                    end
                end
                S_L2_REQ: st <= S_L2_WAIT;
                S_L2_WAIT: if (mem_rd_data_valid) begin
                    st <= S_RESP;
                    if (!ent_usable) begin
                        pa_q  <= safe_pa;
                        rsn_q <= RSN_L2;
                    end else if (wr_q && !ent_wr) begin
                        pa_q  <= safe_pa;
                        rsn_q <= RSN_PERM;
                    end else begin
                        pa_q  <= {ent_hi, ent_pfn, va_q[OFS_W-1:0]};
                        rsn_q <= RSN_NONE;
                    end
                end
                S_RESP:  st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // Handshake, memory port and response outputs driven from state.
    always_comb begin
        req_ready  = (st == S_IDLE);
        mem_rd_req = (st == S_L1_REQ) || (st == S_L2_REQ);
        if (st == S_L2_REQ)
            mem_rd_addr = {l2_base_q, va_q[L1_LSB-1:OFS_W], {WORD_SH{1'b0}}};
        else
            mem_rd_addr = {cfg_root_base[VA_W-1:OFS_W], va_q[VA_W-1:L1_LSB], {WORD_SH{1'b0}}};
        rsp_valid  = (st == S_RESP);
        rsp_paddr  = pa_q;
        rsp_reason = rsn_q;
    end

    ptw_fault_log u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .rec        (rsp_valid && (rsp_reason != RSN_NONE)),
        .rec_reason (rsp_reason),
        .rec_vaddr  (va_q),
        .clear      (fault_clear),
        .log_reason (fault_reason),
        .log_vaddr  (fault_vaddr)
    );

    // R8: once accepted, the walker is busy on the next cycle.
    a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R8: the response is a single-cycle pulse.
    a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R11: never two back-to-back read requests.
    a_r11_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);
    // R9: with translation off, the answer comes next cycle with no fault.
    a_r9_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !cfg_enable) |=> (rsp_valid && rsp_reason == RSN_NONE));
    // R7: any fault points into the safe page.
    a_r7_safe: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_reason != RSN_NONE) |-> (rsp_paddr[PA_W-1:OFS_W] == cfg_safe_page[PA_W-1:OFS_W]));
    // R6: a permission fault only arises on a write.
    a_r6_perm_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_reason == RSN_PERM) |-> wr_q);
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b1;
    logic [31:0] cfg_root_base = 32'h7000_0000;
    logic [39:0] cfg_safe_page = 40'hA5_DEAD_B000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [39:0] rsp_paddr;
    logic [1:0]  rsp_reason;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_data_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        fault_clear = 1'b0;
    logic [1:0]  fault_reason;
    logic [31:0] fault_vaddr;

    int n_tests = 0;
    int n_fail  = 0;
    int mem_reqs = 0;
    int lat_ctr = 0;
    logic [31:0] exp_l1_addr = '0;
    logic [31:0] exp_l2_addr = '0;
    logic [31:0] mem [0:4095];

    always #4 clk = ~clk;   // 125 MHz

    ptw_walker dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] l2_entry(input int t, input int j);
        logic [31:0] pfn;
        logic [7:0]  hi;
        logic [31:0] e;
        pfn = ((t * 32'h1357) ^ (j * 7)) & 32'hFFFFF;
        hi  = 8'((t * 16 + j) & 8'hFF);
        e   = {pfn[19:0], hi, 1'b0, (j % 2 == 0), 1'b0, 1'b1};
        if (j % 4 == 3) e = 32'h2;
        else if (j % 16 == 13) e = e | 32'h2;
        return e;
    endfunction

    // Memory model: one request at a time, latency cycling 1..3, address checks (R2).
    initial begin
        forever begin
            @(negedge clk);
            mem_rd_data_valid = 1'b0;
            if (mem_rd_req) begin
                if (mem_reqs == 0)
                    chk(mem_rd_addr == exp_l1_addr, "R2 l1 address", 64'(mem_rd_addr), 64'(exp_l1_addr));
                else
                    chk(mem_rd_addr == exp_l2_addr, "R2 l2 address", 64'(mem_rd_addr), 64'(exp_l2_addr));
                mem_reqs++;
                mem_rd_data = mem[mem_rd_addr[13:2]];
                lat_ctr = (lat_ctr + 1) % 3;
                repeat (lat_ctr + 1) @(negedge clk);
                mem_rd_data_valid = 1'b1;   // R11 variable latency
            end
        end
    end

    // Issue one request and return the response; reports cycles to response.
    task automatic walk(input logic [31:0] va, input logic wr,
                        output logic [39:0] pa, output logic [1:0] rsn, output int waits);
        @(negedge clk);
        mem_reqs  = 0;
        req_vaddr = va;
        req_write = wr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        waits = 0;
        chk(req_ready == 1'b0 || rsp_valid, "R8 busy after accept", 64'(req_ready), 64'd0);
        while (!rsp_valid && waits < 100) begin
            @(negedge clk);
            waits++;
        end
        pa  = rsp_paddr;
        rsn = rsp_reason;
        @(negedge clk);
        chk(!rsp_valid, "R8 single pulse", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [39:0] pa;
        logic [1:0]  rsn;
        int          waits;
        logic [31:0] ptr [1:3];
        int          l1i [1:3];
        ptr[1] = 32'h4000_1001; ptr[2] = 32'h8000_2001; ptr[3] = 32'hC000_3001;
        l1i[1] = 0; l1i[2] = 517; l1i[3] = 1023;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h2;
        mem[l1i[1]] = ptr[1]; mem[l1i[2]] = ptr[2]; mem[l1i[3]] = ptr[3];
        mem[9] = 32'h4000_1003;   // valid but exception-marked
        for (int t = 1; t <= 3; t++)
            for (int j = 0; j < 1024; j++) mem[t * 1024 + j] = l2_entry(t, j);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk(mem_rd_req == 1'b0, "R1 mem_rd_req", 64'(mem_rd_req), 64'd0);
        chk(fault_reason == 2'b00, "R1 fault_reason", 64'(fault_reason), 64'd0);

        // R10 fault log sequence: first fault held, later ignored, clear empties.
        exp_l1_addr = {20'h70000, 10'd2, 2'b00};
        walk({10'd2, 10'd5, 12'h345}, 1'b0, pa, rsn, waits);
        chk(rsn == 2'b01, "R4 unmapped l1", 64'(rsn), 64'd1);
        exp_l1_addr = {20'h70000, 10'd0, 2'b00};
        exp_l2_addr = {20'h40001, 10'd3, 2'b00};
        walk({10'd0, 10'd3, 12'h111}, 1'b0, pa, rsn, waits);
        chk(rsn == 2'b10, "R5 unmapped l2", 64'(rsn), 64'd2);
        chk(fault_reason == 2'b01, "R10 first reason held", 64'(fault_reason), 64'd1);
        chk(fault_vaddr == {10'd2, 10'd5, 12'h345}, "R10 first vaddr held", 64'(fault_vaddr), 64'({10'd2, 10'd5, 12'h345}));
        @(negedge clk); fault_clear = 1'b1;
        @(negedge clk); fault_clear = 1'b0;
        chk(fault_reason == 2'b00, "R10 cleared", 64'(fault_reason), 64'd0);

        // R3/R5/R6/R7 sweep over every second-level entry, read and write.
        for (int t = 1; t <= 3; t++) begin
            for (int j = 0; j < 1024; j++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [31:0] va;
                    logic [31:0] e;
                    logic [39:0] ep;
                    logic [1:0]  er;
                    va = {10'(l1i[t]), 10'(j), 12'((j * 37 + w) & 12'hFFF)};
                    e  = l2_entry(t, j);
                    exp_l1_addr = {20'h70000, 10'(l1i[t]), 2'b00};
                    exp_l2_addr = {ptr[t][31:12], 10'(j), 2'b00};
                    if (!e[0] || e[1]) begin er = 2'b10; ep = {cfg_safe_page[39:12], va[11:0]}; end
                    else if (w == 1 && !e[2]) begin er = 2'b11; ep = {cfg_safe_page[39:12], va[11:0]}; end
                    else begin er = 2'b00; ep = {e[11:4], e[31:12], va[11:0]}; end
                    walk(va, 1'(w), pa, rsn, waits);
                    chk(rsn == er, "R3 R5 R6 reason", 64'(rsn), 64'(er));
                    chk(pa == ep, (er == 2'b00) ? "R3 paddr" : "R7 safe paddr", 64'(pa), 64'(ep));
                    chk(mem_reqs == 2, "R11 two reads", 64'(mem_reqs), 64'd2);
                end
            end
        end

        // R4 sweep over invalid or exception-marked first-level slots.
        for (int i = 0; i < 1024; i++) begin
            if (i != l1i[1] && i != l1i[2] && i != l1i[3]) begin
                logic [31:0] va;
                va = {10'(i), 10'((i * 3) & 10'h3FF), 12'((i * 5) & 12'hFFF)};
                exp_l1_addr = {20'h70000, 10'(i), 2'b00};
                walk(va, 1'(i % 2), pa, rsn, waits);
                chk(rsn == 2'b01, "R4 l1 reason", 64'(rsn), 64'd1);
                chk(pa == {cfg_safe_page[39:12], va[11:0]}, "R7 l1 safe paddr", 64'(pa), 64'({cfg_safe_page[39:12], va[11:0]}));
                chk(mem_reqs == 1, "R4 no second read", 64'(mem_reqs), 64'd1);
            end
        end

        // R9 pass-through sweep.
        @(negedge clk); cfg_enable = 1'b0;
        for (int k = 0; k < 256; k++) begin
            logic [31:0] va;
            va = 32'(k) * 32'h0101_0F1B;
            walk(va, 1'(k % 2), pa, rsn, waits);
            chk(pa == {8'h00, va}, "R9 paddr", 64'(pa), 64'({8'h00, va}));
            chk(rsn == 2'b00, "R9 reason", 64'(rsn), 64'd0);
            chk(waits == 0, "R9 next-cycle response", 64'(waits), 64'd0);
            chk(mem_reqs == 0, "R9 no memory read", 64'(mem_reqs), 64'd0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule